// File: doc/BRIEF.md
# Event-Aligned Multi-Link Input Synchronizer

This block takes fixed-length event fragments arriving on several parallel input links (six by default) and keeps them aligned event by event. Each link writes into its own region of slot storage. It does not use a plain FIFO. A per-link word counter selects the offset inside the current event slot. As soon as any one link delivers the last word of an event, every link moves to the next slot together. A link that drops a word therefore never pushes the streams out of step. Instead, the event it was short on is marked as erroneous.

The first word of every fragment carries a header identifier in its low bits, for example a pipeline column number. The identifiers of all links that delivered a header for an event are compared, and a disagreement marks the event as erroneous. On the output side, completed events are handed out one at a time through a valid/ready port. Each event is sent link-major: all words of link 0, then all words of link 1, and so on. An error bit is held for the whole event and the final word is flagged. When every slot holds an unread event, the input side raises a stall output and ignores incoming words.

Top module: `evsync_top`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `out_valid` and `in_stall` are 0.
- R2: Each link writes its accepted words at successive offsets 0, 1, 2, ... of the current event slot. The readout returns those words unchanged.
- R3: In the cycle in which any link writes offset EV_WORDS-1, all links advance to the next slot and their word counters restart at 0. The event then becomes readable from the next cycle.
- R4: An event at whose advance some link had not written all EV_WORDS words has its error bit set.
- R5: The low ID_W bits of word 0 are the header identifier. If two links that delivered word 0 for an event disagree on it, the error bit is set. An event with all links complete and matching identifiers has error bit 0.
- R6: After a forced advance, the next word of a link that was short lands at offset 0 of the new slot.
- R7: There are SLOTS event slots (a power of two). When all of them hold unread events, `in_stall` is 1 and input words have no effect on storage, counters or the events read later.
- R8: An event is read link-major: link 0 offsets 0..EV_WORDS-1, then link 1, and so on. `out_last` is 1 only on the final word, and `out_err` is the event's error bit on every word.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_err` hold their values.
- R10: Events are read in the order in which they were completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_LINKS | Per-link word strobe |
| in_data | input | NUM_LINKS*DATA_W | Per-link words, link i at bits [i*DATA_W +: DATA_W] |
| in_stall | output | 1 | All slots full; input words are ignored |
| out_valid | output | 1 | A completed event is being presented |
| out_ready | input | 1 | Consumer accepts the current word |
| out_data | output | DATA_W | Current readout word |
| out_err | output | 1 | Error bit of the event being read |
| out_last | output | 1 | Final word of the event |

## Verification
Input words are written at the clock edge that samples them. The event becomes readable in the next cycle, so the bench drives on falling edges and samples `out_valid`, `out_data`, `out_err` and `out_last` one falling edge after the last word of an event. `in_stall` is combinational from the slot pointers. It is checked on the falling edge just after the edge that filled the fourth slot, and again just after the edge that popped an event. Readout words leave on the rising edge that follows each falling-edge sample, so each word is compared at exactly the falling edge before its handshake.

// File: rtl/evsync_pkg.sv
package evsync_pkg;
  // index width for a count n, never below one bit
  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/evsync_lane.sv
module evsync_lane
  import evsync_pkg::*;
#(
  parameter int EV_WORDS = 35,
  parameter int SLOTS    = 4,
  parameter int DATA_W   = 16,
  parameter int ID_W     = 8,
  localparam int CW = idx_w(EV_WORDS),
  localparam int SW = idx_w(SLOTS),
  localparam int AW = idx_w(SLOTS * EV_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SW-1:0]     wr_slot,
  input  logic              advance,
  input  logic [SW-1:0]     rd_slot,
  input  logic [CW-1:0]     rd_off,
  output logic              done,
  output logic              have_id,
  output logic [ID_W-1:0]   id,
  output logic [DATA_W-1:0] rd_data
);
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            have_q, have_d;
  logic [ID_W-1:0] id_q, id_d;
  logic            at_head;
  logic            upd_en;
  logic [AW-1:0]   wa, ra;
  logic [DATA_W-1:0] mem [SLOTS*EV_WORDS];

  assign at_head = wr_en && (cnt_q == '0);
  assign done    = wr_en && (int'(cnt_q) == EV_WORDS - 1);
  assign upd_en  = advance | wr_en;

  always_comb begin
    cnt_d  = cnt_q;
    if (advance)    cnt_d = '0;
    else if (wr_en) cnt_d = cnt_q + 1'b1;
    have_d = advance ? 1'b0 : (have_q | at_head);
    id_d   = at_head ? wr_data[ID_W-1:0] : id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      have_q <= 1'b0;
      id_q   <= '0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      have_q <= have_d;
      id_q   <= id_d;
    end
  end

  // header identifier as seen for the event closing in this cycle
  assign have_id = have_q | at_head;
  assign id      = at_head ? wr_data[ID_W-1:0] : id_q;

  assign wa = AW'(int'(wr_slot) * EV_WORDS + int'(cnt_q));
  assign ra = AW'(int'(rd_slot) * EV_WORDS + int'(rd_off));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
  end

  assign rd_data = mem[ra];

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < EV_WORDS);
  a_r6_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (cnt_q == '0));
endmodule

// File: rtl/evsync_ctrl.sv
module evsync_ctrl
  import evsync_pkg::*;
#(
  parameter int NUM_LINKS = 6,
  parameter int SLOTS     = 4,
  parameter int ID_W      = 8,
  localparam int SW = idx_w(SLOTS),
  localparam int PW = SW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINKS-1:0]   done,
  input  logic [NUM_LINKS-1:0]   have,
  input  logic [NUM_LINKS*ID_W-1:0] ids,
  input  logic                   rd_pop,
  output logic                   advance,
  output logic                   full,
  output logic                   avail,
  output logic [SW-1:0]          wslot,
  output logic [SW-1:0]          rslot,
  output logic                   err_head
);
  logic [PW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d, occ;
  logic [SLOTS-1:0] err_q, err_d;
  logic             mism, seen, err_now;
  logic [ID_W-1:0]  ref_id;

  assign advance = |done;

  always_comb begin
    seen   = 1'b0;
    mism   = 1'b0;
    ref_id = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (have[i]) begin
        if (!seen) begin
          seen   = 1'b1;
          ref_id = ids[i*ID_W +: ID_W];
        end else if (ids[i*ID_W +: ID_W] != ref_id) begin
          mism = 1'b1;
        end
      end
    end
  end

  assign err_now = ~(&done) | mism;

  always_comb begin
    wptr_d = wptr_q + PW'(advance);
    rptr_d = rptr_q + PW'(rd_pop);
    err_d  = err_q;
    if (advance) err_d[wslot] = err_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      err_q  <= '0;
    end else begin
      if (advance) begin
        wptr_q <= wptr_d;
        err_q  <= err_d;
      end
      if (rd_pop) rptr_q <= rptr_d;
    end
  end

  assign occ      = wptr_q - rptr_q;
  assign full     = (occ == PW'(SLOTS));
  assign avail    = (occ != '0);
  assign wslot    = wptr_q[SW-1:0];
  assign rslot    = rptr_q[SW-1:0];
  assign err_head = err_q[rslot];

  a_r7_no_advance_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !advance);
  a_r7_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= SLOTS);
  a_r10_pop_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> avail);
endmodule

// File: rtl/evsync_reader.sv
module evsync_reader
  import evsync_pkg::*;
#(
  parameter int NUM_LINKS = 6,
  parameter int EV_WORDS  = 35,
  localparam int LW = idx_w(NUM_LINKS),
  localparam int CW = idx_w(EV_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          avail,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [LW-1:0] rlink,
  output logic [CW-1:0] roff,
  output logic          last,
  output logic          pop
);
  logic [LW-1:0] rlink_d;
  logic [CW-1:0] roff_d;
  logic          fire, off_end;

  assign out_valid = avail;
  assign fire      = avail & out_ready;
  assign off_end   = (int'(roff) == EV_WORDS - 1);
  assign last      = off_end && (int'(rlink) == NUM_LINKS - 1);
  assign pop       = fire & last;

  always_comb begin
    rlink_d = rlink;
    roff_d  = roff + 1'b1;
    if (off_end) begin
      roff_d  = '0;
      rlink_d = last ? '0 : rlink + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rlink <= '0;
      roff  <= '0;
    end else if (fire) begin
      rlink <= rlink_d;
      roff  <= roff_d;
    end
  end

  a_r8_idle_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !avail |-> (rlink == '0 && roff == '0));
endmodule

// File: rtl/evsync_top.sv
module evsync_top
  import evsync_pkg::*;
#(
  parameter int NUM_LINKS = 6,
  parameter int EV_WORDS  = 35,
  parameter int SLOTS     = 4,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINKS-1:0]        in_valid,
  input  logic [NUM_LINKS*DATA_W-1:0] in_data,
  output logic                        in_stall,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [DATA_W-1:0]           out_data,
  output logic                        out_err,
  output logic                        out_last
);
  localparam int SW = idx_w(SLOTS);
  localparam int CW = idx_w(EV_WORDS);
  localparam int LW = idx_w(NUM_LINKS);

  logic [NUM_LINKS-1:0]      done, have;
  logic [NUM_LINKS*ID_W-1:0] ids;
  logic [DATA_W-1:0]         lane_rd [NUM_LINKS];
  logic                      advance, full, avail, pop;
  logic [SW-1:0]             wslot, rslot;
  logic [LW-1:0]             rlink;
  logic [CW-1:0]             roff;

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_lane
    logic wr_en;
    assign wr_en = in_valid[g] & ~full;
    evsync_lane #(
      .EV_WORDS(EV_WORDS), .SLOTS(SLOTS), .DATA_W(DATA_W), .ID_W(ID_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (in_data[g*DATA_W +: DATA_W]),
      .wr_slot (wslot),
      .advance (advance),
      .rd_slot (rslot),
      .rd_off  (roff),
      .done    (done[g]),
      .have_id (have[g]),
      .id      (ids[g*ID_W +: ID_W]),
      .rd_data (lane_rd[g])
    );
  end

  evsync_ctrl #(
    .NUM_LINKS(NUM_LINKS), .SLOTS(SLOTS), .ID_W(ID_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .have     (have),
    .ids      (ids),
    .rd_pop   (pop),
    .advance  (advance),
    .full     (full),
    .avail    (avail),
    .wslot    (wslot),
    .rslot    (rslot),
    .err_head (out_err)
  );

  evsync_reader #(
    .NUM_LINKS(NUM_LINKS), .EV_WORDS(EV_WORDS)
  ) u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .avail     (avail),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rlink     (rlink),
    .roff      (roff),
    .last      (out_last),
    .pop       (pop)
  );

  always_comb begin
    out_data = '0;
    for (int i = 0; i < NUM_LINKS; i++)
      if (int'(rlink) == i) out_data = lane_rd[i];
  end

  assign in_stall = full;

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));
  a_r3_advance_makes_event: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> out_valid);
  a_r7_stall_blocks_done: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall |-> (done == '0));
endmodule

// File: tb/evsync_top_test.sv
`timescale 1ns/1ps
module evsync_top_test;
  localparam int L  = 6;
  localparam int EV = 4;
  localparam int SL = 4;
  localparam int DW = 12;
  localparam int IW = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [L-1:0]    in_valid;
  logic [L*DW-1:0] in_data;
  logic            in_stall, out_valid, out_ready, out_err, out_last;
  logic [DW-1:0]   out_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  evsync_top #(.NUM_LINKS(L), .EV_WORDS(EV), .SLOTS(SL), .DATA_W(DW), .ID_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_stall(in_stall), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err(out_err), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // word layout: {link[2:0], event tag[4:0], low4}; low4 is the header id on offset 0
  function automatic logic [DW-1:0] expw(input int l, input int ev, input int o, input int bad);
    logic [3:0] low;
    if (o == 0) low = 4'(ev) ^ ((l == bad) ? 4'd1 : 4'd0);
    else        low = 4'(o);
    return {3'(l), 5'(ev), low};
  endfunction

  task automatic send_event(input int ev, input logic [L-1:0] short_mask, input int bad);
    for (int o = 0; o < EV; o++) begin
      @(negedge clk);
      for (int l = 0; l < L; l++) begin
        in_valid[l] = !(short_mask[l] && o == EV - 1);
        in_data[l*DW +: DW] = expw(l, ev, o, bad);
      end
    end
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic read_event(input int ev, input logic [L-1:0] short_mask, input int bad);
    bit exp_err;
    exp_err = (short_mask != '0) || (bad >= 0);
    for (int l = 0; l < L; l++) begin
      for (int o = 0; o < EV; o++) begin
        @(negedge clk);
        out_ready = 1'b1;
        chk(out_valid === 1'b1, "R10 event available", int'(out_valid), 1);
        if (!(short_mask[l] && o == EV - 1))
          chk(out_data === expw(l, ev, o, bad), "R2/R6 word content", int'(out_data),
              int'(expw(l, ev, o, bad)));
        chk(out_last === (l == L - 1 && o == EV - 1), "R8 last flag", int'(out_last),
            int'(l == L - 1 && o == EV - 1));
        if (short_mask != '0)
          chk(out_err === exp_err, "R4 short-link error", int'(out_err), int'(exp_err));
        else
          chk(out_err === exp_err, "R5 header compare error", int'(out_err), int'(exp_err));
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    rst_n = 1'b0;
    in_valid = '0;
    in_data = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_stall === 1'b0, "R1 in_stall after reset", int'(in_stall), 0);

    // R2 R3 R10: three clean events back to back, read afterwards in order
    for (int e = 0; e < 3; e++) send_event(e, '0, -1);
    for (int e = 0; e < 3; e++) read_event(e, '0, -1);

    // R4 R6: link 2 drops its last word; the next event must start at offset 0
    send_event(3, 6'b000100, -1);
    send_event(4, '0, -1);
    read_event(3, 6'b000100, -1);
    read_event(4, '0, -1);

    // R4 sweep: each link short in turn, plus two links short together
    for (int l = 0; l < L; l++) begin
      send_event(5 + l, 6'(1 << l), -1);
      read_event(5 + l, 6'(1 << l), -1);
    end
    send_event(11, 6'b100001, -1);
    read_event(11, 6'b100001, -1);

    // R5 sweep: each link with a disagreeing header id
    for (int l = 0; l < L; l++) begin
      send_event(12 + l, '0, l);
      read_event(12 + l, '0, l);
    end

    // R7: fill all slots, words during stall must have no effect
    for (int e = 0; e < SL; e++) send_event(18 + e, '0, -1);
    chk(in_stall === 1'b1, "R7 stall when full", int'(in_stall), 1);
    for (int o = 0; o < EV; o++) begin
      @(negedge clk);
      in_valid = '1;
      in_data = '1;
      chk(in_stall === 1'b1, "R7 stall held", int'(in_stall), 1);
    end
    @(negedge clk);
    in_valid = '0;
    read_event(18, '0, -1);
    chk(in_stall === 1'b0, "R7 stall released after pop", int'(in_stall), 0);
    for (int e = 1; e < SL; e++) read_event(18 + e, '0, -1);
    send_event(22, '0, -1);
    read_event(22, '0, -1);

    // R9: hold while not ready
    send_event(23, '0, -1);
    @(negedge clk);
    held = out_data;
    chk(held === expw(0, 23, 0, -1), "R9 first word", int'(held), int'(expw(0, 23, 0, -1)));
    repeat (3) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === held, "R9 hold while not ready",
          int'(out_data), int'(held));
    end
    read_event(23, '0, -1);
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 drained", int'(out_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule